// File: doc/BRIEF.md
# Trigger Delay Sequencing Controller

This block is the digital sequencer of a coarse-plus-fine delay generator. A trigger arrives with no fixed phase relation to a stable reference clock. The controller turns an external ramp on from the trigger, stops it at a clock edge, counts a coarse number of clock periods, and then turns the ramp on again until an external comparator trips. The two ramp intervals together always add up to the same fixed amount, so the delay from trigger to sample pulse does not depend on where the trigger falls inside a clock period.

When the comparator trips, the controller emits the sample pulse. It also sets an idle latch, which holds the ramp in reset and signals ready, raises an interrupt and drops the halt signal. A re-arm strobe clears the idle latch, and only then is another trigger accepted. A power-on load strobe sets the idle latch. An acknowledge strobe clears the interrupt and cuts the hold strobe short. The ramp, the hold circuit, the comparator and the fine-delay converter are outside this block and appear only as its signals.

Trigger and comparator inputs each pass through a two-stage synchronizer followed by rising-edge detection. The latency this adds is the same on every run.

Top module: `trig_delay_seq`

## Requirements
- R1: After reset, ready_o=1, ramp_rst_o=1, and ramp_en_o, hold_o, sample_o, irq_o and halt_o are all 0.
- R2: An arm_i strobe clears ready_o and ramp_rst_o from the next cycle. A load_i strobe sets both of them from the next cycle, and load_i wins when both strobes arrive in the same cycle.
- R3: When armed and idle, a rising trigger edge raises ramp_en_o, hold_o and halt_o together, just after the third rising clock edge at or after the trigger edge.
- R4: hold_o stays high for exactly HOLD_CYC cycles (660, which is 3.3 us at 200 MHz). An ack_i strobe drops it from the next cycle.
- R5: The first ramp interval lasts exactly one cycle. ramp_en_o then stays low for exactly N+2 cycles before it rises again, where N is count_i sampled at acceptance. This covers N=0 and N=255.
- R6: During the second ramp interval, a rising comparator edge lowers ramp_en_o and raises sample_o, just after the third rising clock edge at or after the comparator edge. sample_o then lasts SMP_CYC (2) cycles.
- R7: In the cycle sample_o rises, irq_o=1, ready_o=1, ramp_rst_o=1 and halt_o=0.
- R8: An ack_i strobe clears irq_o from the next cycle.
- R9: Trigger edges that occur while a sequence runs, or while ready_o=1, start nothing. An edge seen while ready_o=1 is not remembered after re-arming.
- R10: A comparator edge outside the second ramp interval produces no sample pulse.
- R11: The second rise of ramp_en_o comes N+5 clock edges after the first edge at or after the trigger, for every trigger phase within the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger, asynchronous |
| cmp_i | input | 1 | Comparator tripped, asynchronous |
| count_i | input | CNT_W | Coarse delay count in clock periods |
| load_i | input | 1 | Power-on load strobe, sets idle latch |
| arm_i | input | 1 | Re-arm strobe, clears idle latch |
| ack_i | input | 1 | New-data acknowledge |
| ramp_en_o | output | 1 | Ramp running |
| ramp_rst_o | output | 1 | Ramp held at its initial level |
| hold_o | output | 1 | Sample-and-hold strobe |
| sample_o | output | 1 | Sample pulse |
| ready_o | output | 1 | Ready for a new trigger after arming |
| irq_o | output | 1 | Interrupt request |
| halt_o | output | 1 | Halt while a delay is in progress |

## Verification
The assertions assume three things about the inputs. load_i, arm_i and ack_i are single-cycle strobes that are synchronous to clk_i. count_i is stable at the cycle of acceptance. trig_i and cmp_i hold each level for at least one full cycle, so the synchronizers see every edge. The stimulus drives the strobes and count_i only at falling clock edges. It places trigger edges between 0.5 ns and 4.5 ns after a rising edge, so they are clear of the sampling edge. Comparator edges are raised only at falling edges and held for at least one cycle.

// File: rtl/trig_delay_pkg.sv
`timescale 1ns/1ps
package trig_delay_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAMP_A,
    ST_GATE,
    ST_COUNT,
    ST_RAMP_B
  } seq_state_e;
endpackage

// File: rtl/tds_sync_edge.sv
`timescale 1ns/1ps
module tds_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tds_pulse_timer.sv
`timescale 1ns/1ps
module tds_pulse_timer #(
  parameter int unsigned LEN = 2,
  localparam int unsigned W = $clog2(LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic kill_i,
  output logic act_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= W'(LEN);
    else if (kill_i)        cnt_q <= '0;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign act_o = (cnt_q != '0);
endmodule

// File: rtl/tds_coarse_ctr.sv
`timescale 1ns/1ps
module tds_coarse_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/trig_delay_seq.sv
`timescale 1ns/1ps
module trig_delay_seq
  import trig_delay_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYC    = 660,  // 3.3 us at 200 MHz
  parameter int unsigned SMP_CYC     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             cmp_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             load_i,
  input  logic             arm_i,
  input  logic             ack_i,
  output logic             ramp_en_o,
  output logic             ramp_rst_o,
  output logic             hold_o,
  output logic             sample_o,
  output logic             ready_o,
  output logic             irq_o,
  output logic             halt_o
);
  seq_state_e st_q, st_d;
  logic trig_rise, cmp_rise, cnt_zero;
  logic idle_lat_q, irq_q, halt_q;
  logic accept, smp_lead, cnt_dec;

  tds_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk_i, .rst_ni, .d_i(trig_i), .rise_o(trig_rise)
  );

  tds_sync_edge #(.STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk_i, .rst_ni, .d_i(cmp_i), .rise_o(cmp_rise)
  );

  assign accept   = (st_q == ST_IDLE) && !idle_lat_q && trig_rise;
  assign smp_lead = (st_q == ST_RAMP_B) && cmp_rise;
  assign cnt_dec  = (st_q == ST_COUNT) && !cnt_zero;

  tds_coarse_ctr #(.W(CNT_W)) u_ctr (
    .clk_i, .rst_ni,
    .load_i(accept), .val_i(count_i), .dec_i(cnt_dec), .zero_o(cnt_zero)
  );

  tds_pulse_timer #(.LEN(HOLD_CYC)) u_hold (
    .clk_i, .rst_ni, .start_i(accept), .kill_i(ack_i), .act_o(hold_o)
  );

  tds_pulse_timer #(.LEN(SMP_CYC)) u_smp (
    .clk_i, .rst_ni, .start_i(smp_lead), .kill_i(1'b0), .act_o(sample_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept) st_d = ST_RAMP_A;
      ST_RAMP_A: st_d = ST_GATE;     // first clock edge ends interval A
      ST_GATE:   st_d = ST_COUNT;    // next edge starts the countdown
      ST_COUNT:  if (cnt_zero) st_d = ST_RAMP_B;
      ST_RAMP_B: if (cmp_rise) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
    if (load_i) st_d = ST_IDLE;      // latch set clears ramp control at once
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      idle_lat_q <= 1'b1;
      irq_q      <= 1'b0;
      halt_q     <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load_i || smp_lead) idle_lat_q <= 1'b1;
      else if (arm_i)         idle_lat_q <= 1'b0;
      if (smp_lead)           irq_q <= 1'b1;
      else if (ack_i)         irq_q <= 1'b0;
      if (accept)             halt_q <= 1'b1;
      else if (smp_lead)      halt_q <= 1'b0;
    end
  end

  assign ramp_en_o  = (st_q == ST_RAMP_A) || (st_q == ST_RAMP_B);
  assign ramp_rst_o = idle_lat_q;
  assign ready_o    = idle_lat_q;
  assign irq_o      = irq_q;
  assign halt_o     = halt_q;
endmodule

// File: rtl/tds_checker.sv
`timescale 1ns/1ps
module tds_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic load_i,
  input logic ack_i,
  input logic ramp_en_o,
  input logic ramp_rst_o,
  input logic hold_o,
  input logic sample_o,
  input logic ready_o,
  input logic irq_o,
  input logic halt_o
);
  // R2
  load_sets_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ready_o && ramp_rst_o));

  // R3
  accept_together_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> (ramp_en_o && hold_o));

  // R4
  ack_kills_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (!hold_o || $rose(halt_o)));

  // R5
  first_ramp_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |=> !ramp_en_o);

  // R6
  sample_ends_ramp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_o) |-> (!ramp_en_o && $past(ramp_en_o)));

  // R7
  sample_lead_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_o) |-> (irq_o && ready_o && !halt_o));

  // R8
  ack_clears_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (!irq_o || $rose(sample_o)));

  // R9
  idle_no_ramp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !ramp_en_o);
endmodule

bind trig_delay_seq tds_checker u_chk (.*);

// File: tb/sim_trig_delay_seq.sv
`timescale 1ns/1ps
module sim_trig_delay_seq;
  localparam int CW   = 8;
  localparam int HOLD = 660;
  localparam int SMP  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig = 1'b0, cmp = 1'b0, load = 1'b0, arm = 1'b0, ack = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic ramp_en, ramp_rst, hold, sample, ready, irq, halt;

  trig_delay_seq #(.CNT_W(CW), .SYNC_STAGES(2), .HOLD_CYC(HOLD), .SMP_CYC(SMP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .cmp_i(cmp), .count_i(cnt),
    .load_i(load), .arm_i(arm), .ack_i(ack),
    .ramp_en_o(ramp_en), .ramp_rst_o(ramp_rst), .hold_o(hold), .sample_o(sample),
    .ready_o(ready), .irq_o(irq), .halt_o(halt)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
    chk(!ready && !ramp_rst, "R2 arm clears ready", int'({ready, ramp_rst}), 0);
  endtask

  task automatic do_ack();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
    chk(!irq, "R8 ack clears irq", int'(irq), 0);
  endtask

  task automatic test_reset();
    chk({ramp_en, ramp_rst, hold, sample, ready, irq, halt} == 7'b0100100,
        "R1 reset state", int'({ramp_en, ramp_rst, hold, sample, ready, irq, halt}), 7'b0100100);
  endtask

  task automatic test_load();
    do_arm();
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    chk(ready && ramp_rst, "R2 load sets ready", int'({ready, ramp_rst}), 3);
    do_arm();
    @(negedge clk) begin load = 1'b1; arm = 1'b1; end
    @(negedge clk) begin load = 1'b0; arm = 1'b0; end
    chk(ready, "R2 load beats arm", int'(ready), 1);
  endtask

  // edge index k: 0 = first rising clock edge at or after the trigger edge
  task automatic run_seq(input int n, input real ph, input int d, input bit glitch);
    int t, k, r1, f1, r2, s1, sw;
    bit pr, ps;
    r1 = -1; f1 = -1; r2 = -1; s1 = -1; sw = 0; pr = 1'b0; ps = 1'b0;
    do_arm();
    @(negedge clk) cnt = CW'(n);
    @(posedge clk);
    #(ph);
    trig = 1'b1;
    t = cyc;
    for (int i = 0; i < n + 60; i++) begin
      @(negedge clk);
      k = cyc - t - 1;
      if (k == 2)
        chk(hold && halt && ramp_en, "R3 accept outputs", int'({hold, halt, ramp_en}), 7);
      if (glitch && k == 3) cmp = 1'b1;   // R10 early comparator edge
      if (glitch && k == 4) begin cmp = 1'b0; trig = 1'b0; end
      if (glitch && k == 5) trig = 1'b1;  // R9 second trigger edge mid-run
      if (ramp_en && !pr) begin
        if (r1 < 0) r1 = k;
        else if (r2 < 0) r2 = k;
      end
      if (!ramp_en && pr && f1 < 0) f1 = k;
      if (r2 >= 0 && k == r2 + d) cmp = 1'b1;
      if (sample && !ps && s1 < 0) begin
        s1 = k;
        chk(irq && ready && ramp_rst && !halt, "R7 sample lead flags",
            int'({irq, ready, ramp_rst, halt}), 14);
      end
      if (sample) sw++;
      pr = ramp_en;
      ps = sample;
      if (s1 >= 0 && k >= s1 + SMP + 1) break;
    end
    chk(r1 == 2, "R3 accept edge", r1, 2);
    chk(f1 == 3, "R5 first interval one cycle", f1, 3);
    chk(r2 == n + 5, "R11 ramp restart edge", r2, n + 5);
    chk(r2 - f1 == n + 2, "R5 ramp off length", r2 - f1, n + 2);
    chk(s1 == n + d + 8, "R6 sample edge", s1, n + d + 8);
    chk(sw == SMP, "R6 sample width", sw, SMP);
    if (glitch) chk(s1 == n + d + 8 && !halt, "R9 R10 stray edges ignored", s1, n + d + 8);
    trig = 1'b0;
    cmp  = 1'b0;
    do_ack();
    idle(4);
  endtask

  task automatic test_hold();
    int hl;
    hl = 0;
    do_arm();
    @(negedge clk) begin cnt = CW'(1); trig = 1'b1; end
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (hold) hl++;
      else if (hl > 0) break;
    end
    chk(hl == HOLD, "R4 hold width", hl, HOLD);
    @(negedge clk) cmp = 1'b1;
    idle(6);
    cmp = 1'b0;
    trig = 1'b0;
    chk(irq, "R7 irq after long run", int'(irq), 1);
    do_ack();
    idle(4);
    do_arm();
    @(negedge clk) trig = 1'b1;
    idle(10);
    chk(hold, "R4 hold running", int'(hold), 1);
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
    chk(!hold, "R4 ack clears hold", int'(hold), 0);
    @(negedge clk) cmp = 1'b1;
    idle(8);
    cmp = 1'b0;
    trig = 1'b0;
    do_ack();
    idle(4);
  endtask

  task automatic test_ignore();
    bit seen;
    seen = 1'b0;
    // latched: trigger and comparator edges do nothing
    @(negedge clk) begin trig = 1'b1; cmp = 1'b1; end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ramp_en || halt || sample) seen = 1'b1;
    end
    chk(!seen, "R9 R10 latched edges ignored", int'(seen), 0);
    cmp = 1'b0;
    do_arm();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ramp_en || halt) seen = 1'b1;
    end
    chk(!seen, "R9 edge before arm forgotten", int'(seen), 0);
    trig = 1'b0;
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    idle(4);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_load();
    run_seq(3, 1.0, 2, 1'b0);
    run_seq(0, 4.2, 0, 1'b0);
    run_seq(7, 2.6, 1, 1'b0);
    run_seq(4, 3.7, 3, 1'b1);
    run_seq(255, 0.7, 1, 1'b0);
    test_hold();
    test_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule